// File: doc/BRIEF.md
# Direct-Store Move Decode Checker

This block sits behind an instruction prefix parser. It takes an instruction that has already been split into fields and decides whether it is a legal 32-bit or 64-bit direct-store move, meaning a store from a general register to memory that skips the cache. The fields it examines are:

- the prefix flags;
- up to three opcode bytes and the number of those bytes that are present;
- the mod and reg fields of the ModR/M byte;
- the execution mode;
- a feature-enable bit that reports whether the capability exists.

The upstream logic pulses `in_valid` once per instruction. One cycle later the block presents its verdict:

- a valid flag;
- the operand size;
- the 4-bit source register index;
- a 2-bit fault code.

On cycles with no verdict pending, every output sits at zero.

The block decides in two steps. It first checks that the encoding really is this instruction: the exact three opcode bytes, no mandatory repeat prefix, and a memory destination. Only when that step passes does it apply the conditions that make the instruction undefined. These are a missing feature, a LOCK prefix, or an operand-size override. The REX bits count only in 64-bit mode. Elsewhere the operand size is always 32 bits and the register index has only three significant bits.

Top module: `dstore_decode_chk`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_size64`, `out_src` and `out_fault` are all zero.
- R2: The encoding is recognised only when `op_len` is 3, `op_bytes[7:0]`=0x0F, `op_bytes[15:8]`=0x38, `op_bytes[23:16]`=0xF9, and both `pfx_rep` and `pfx_repne` are 0. Any other opcode or length, or either repeat prefix, gives fault code 2'b10. This check takes priority over every undefined-opcode condition.
- R3: `modrm_mod` equal to 2'b11 (register destination) gives fault code 2'b10. Mod values 2'b00, 2'b01 and 2'b10 are accepted.
- R4: A recognised encoding with `feat_en`=0 gives fault code 2'b01 (undefined opcode).
- R5: A recognised encoding with `pfx_lock`=1 or `pfx_opsize`=1 gives fault code 2'b01.
- R6: The operand size is 32 bits (`out_size64`=0) by default. It is 64 bits only when `exec_mode`=2'b10 (64-bit mode), `rex_present`=1 and `rex_w`=1.
- R7: In 64-bit mode, `out_src` is {`rex_present` AND `rex_r`, `modrm_reg`}, so REX.R reaches registers 8 to 15.
- R8: In any mode other than 2'b10 (00 real, 01 protected/compatibility, 11 treated as non-64), the REX bits are ignored: `out_size64`=0 and `out_src[3]`=0.
- R9: The verdict appears in the cycle right after the cycle in which `in_valid` is sampled high. Back-to-back pulses give back-to-back verdicts. A cycle after a cycle with `in_valid` low shows `out_valid`=0 and `out_fault`=2'b00.
- R10: In a verdict cycle, `out_valid` is 1 exactly when the fault code is 2'b00. When `out_valid` is 0, `out_size64` and `out_src` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle pulse: the instruction fields are present |
| pfx_lock | input | 1 | LOCK prefix seen |
| pfx_opsize | input | 1 | Operand-size override (66H) prefix seen |
| pfx_rep | input | 1 | F3H prefix seen |
| pfx_repne | input | 1 | F2H prefix seen |
| rex_present | input | 1 | A REX prefix is present |
| rex_w | input | 1 | REX.W bit |
| rex_r | input | 1 | REX.R bit |
| op_len | input | 2 | Number of opcode bytes |
| op_bytes | input | 24 | Opcode bytes, first byte in bits 7:0 |
| modrm_mod | input | 2 | ModR/M mod field |
| modrm_reg | input | 3 | ModR/M reg field (source register) |
| exec_mode | input | 2 | 00 real, 01 protected/compatibility, 10 64-bit, 11 treated as non-64 |
| feat_en | input | 1 | Feature-enable (capability) bit |
| out_valid | output | 1 | Legal direct-store move |
| out_size64 | output | 1 | 1 = 64-bit operand, 0 = 32-bit |
| out_src | output | 4 | Source register index |
| out_fault | output | 2 | 00 none, 01 undefined opcode, 10 not this instruction |

## Verification
The assertions check on every cycle the properties that involve a single condition:

- idle cycles stay quiet;
- a set valid flag never comes with a fault, and a clear one zeroes the operand fields;
- a register-form destination always gives the "not this instruction" code;
- a missing feature bit or a forbidden prefix never yields a valid result;
- outside 64-bit mode neither the size nor the register extension can rise;
- the low index bits follow the reg field.

Only the bench scenarios show the complete fault code for combined conditions and the priority of opcode mismatch over undefined-opcode faults. The same holds for the exact opcode-byte and length comparison and for the size and index values produced by each mix of REX bits and mode.

// File: rtl/dstore_decode_pkg.sv
package dstore_decode_pkg;

    localparam int OPC_BYTES = 3;
    localparam int OPC_LEN_W = $clog2(OPC_BYTES + 1);
    localparam int REG_W     = 3;
    localparam int SRC_W     = REG_W + 1;
    localparam int MOD_W     = 2;

    localparam logic [OPC_BYTES*8-1:0] DSTORE_OPC = 24'hF9_38_0F;
    localparam logic [MOD_W-1:0]       MOD_REGFORM = 2'b11;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_UD    = 2'b01,
        FLT_OTHER = 2'b10
    } dsd_fault_e;

    typedef enum logic [1:0] {
        MD_REAL   = 2'b00,
        MD_PROT   = 2'b01,
        MD_LONG64 = 2'b10,
        MD_RSVD   = 2'b11
    } dsd_mode_e;

    typedef struct packed {
        logic               lock;
        logic               opsize;
        logic               rep;
        logic               repne;
    } dsd_pfx_t;

    typedef struct packed {
        logic               present;
        logic               w;
        logic               r;
    } dsd_rex_t;

    typedef struct packed {
        logic               valid;
        logic               size64;
        logic [SRC_W-1:0]   src;
        dsd_fault_e         fault;
    } dsd_result_t;

    function automatic logic is_long_mode(input dsd_mode_e m);
        return m == MD_LONG64;
    endfunction

    function automatic dsd_fault_e pick_fault(input logic recognised, input logic undef);
        if (!recognised) return FLT_OTHER;
        if (undef)       return FLT_UD;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/dstore_opc_match.sv
module dstore_opc_match
    import dstore_decode_pkg::*;
#(
    parameter int                  NBYTES  = OPC_BYTES,
    parameter int                  LEN_W   = OPC_LEN_W,
    parameter logic [NBYTES*8-1:0] PATTERN = DSTORE_OPC
) (
    input  logic [NBYTES*8-1:0] op_bytes,
    input  logic [LEN_W-1:0]    op_len,
    input  dsd_pfx_t            pfx,
    input  logic [MOD_W-1:0]    mod_f,
    output logic                recognised
);
    logic [NBYTES-1:0] byte_eq;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_eq[g] = op_bytes[g*8 +: 8] == PATTERN[g*8 +: 8];
    end

    logic len_ok;
    logic pfx_ok;
    logic mem_form;

    always_comb begin
        len_ok     = op_len == LEN_W'(NBYTES);
        pfx_ok     = !(pfx.rep || pfx.repne);
        mem_form   = mod_f != MOD_REGFORM;
        recognised = (&byte_eq) && len_ok && pfx_ok && mem_form;
    end
endmodule

// File: rtl/dstore_ud_eval.sv
module dstore_ud_eval
    import dstore_decode_pkg::*;
(
    input  dsd_pfx_t pfx,
    input  logic     feat_en,
    output logic     undef
);
    logic bad_prefix;

    always_comb begin
        bad_prefix = pfx.lock || pfx.opsize;
        undef      = bad_prefix || !feat_en;
    end
endmodule

// File: rtl/dstore_opnd_sel.sv
module dstore_opnd_sel
    import dstore_decode_pkg::*;
(
    input  dsd_mode_e         mode,
    input  dsd_rex_t          rex,
    input  logic [REG_W-1:0]  reg_f,
    output logic              size64,
    output logic [SRC_W-1:0]  src
);
    logic rex_live;

    always_comb begin
        rex_live = is_long_mode(mode) && rex.present;
        size64   = rex_live && rex.w;
        src      = {rex_live && rex.r, reg_f};
    end
endmodule

// File: rtl/dstore_decode_chk.sv
module dstore_decode_chk
    import dstore_decode_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   pfx_lock,
    input  logic                   pfx_opsize,
    input  logic                   pfx_rep,
    input  logic                   pfx_repne,
    input  logic                   rex_present,
    input  logic                   rex_w,
    input  logic                   rex_r,
    input  logic [OPC_LEN_W-1:0]   op_len,
    input  logic [OPC_BYTES*8-1:0] op_bytes,
    input  logic [MOD_W-1:0]       modrm_mod,
    input  logic [REG_W-1:0]       modrm_reg,
    input  logic [1:0]             exec_mode,
    input  logic                   feat_en,
    output logic                   out_valid,
    output logic                   out_size64,
    output logic [SRC_W-1:0]       out_src,
    output logic [1:0]             out_fault
);
    dsd_pfx_t    pfx;
    dsd_rex_t    rex;
    dsd_mode_e   mode;
    logic        recognised;
    logic        undef;
    logic        sel_size64;
    logic [SRC_W-1:0] sel_src;
    dsd_result_t nxt;
    dsd_result_t res_q;

    assign pfx  = '{lock: pfx_lock, opsize: pfx_opsize, rep: pfx_rep, repne: pfx_repne};
    assign rex  = '{present: rex_present, w: rex_w, r: rex_r};
    assign mode = dsd_mode_e'(exec_mode);

    dstore_opc_match #(
        .NBYTES (OPC_BYTES),
        .LEN_W  (OPC_LEN_W),
        .PATTERN(DSTORE_OPC)
    ) u_match (
        .op_bytes  (op_bytes),
        .op_len    (op_len),
        .pfx       (pfx),
        .mod_f     (modrm_mod),
        .recognised(recognised)
    );

    dstore_ud_eval u_ud (
        .pfx    (pfx),
        .feat_en(feat_en),
        .undef  (undef)
    );

    dstore_opnd_sel u_opnd (
        .mode  (mode),
        .rex   (rex),
        .reg_f (modrm_reg),
        .size64(sel_size64),
        .src   (sel_src)
    );

    always_comb begin
        nxt.fault  = pick_fault(recognised, undef);
        nxt.valid  = nxt.fault == FLT_NONE;
        nxt.size64 = nxt.valid && sel_size64;
        nxt.src    = nxt.valid ? sel_src : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{valid: 1'b0, size64: 1'b0, src: '0, fault: FLT_NONE};
        end else if (in_valid) begin
            res_q <= nxt;
        end else begin
            res_q <= '{valid: 1'b0, size64: 1'b0, src: '0, fault: FLT_NONE};
        end
    end

    assign out_valid  = res_q.valid;
    assign out_size64 = res_q.size64;
    assign out_src    = res_q.src;
    assign out_fault  = res_q.fault;
endmodule

// File: rtl/dstore_decode_sva.sv
module dstore_decode_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       pfx_lock,
    input logic       pfx_opsize,
    input logic       rex_w,
    input logic [1:0] modrm_mod,
    input logic [2:0] modrm_reg,
    input logic [1:0] exec_mode,
    input logic       feat_en,
    input logic       out_valid,
    input logic       out_size64,
    input logic [3:0] out_src,
    input logic [1:0] out_fault
);
    // R1: outputs are cleared in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_size64 && out_src == 4'd0 && out_fault == 2'b00));

    // R9: a cycle without a pulse leaves the next cycle quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_fault == 2'b00));

    // R10: the valid flag and a fault code never appear together
    p_valid_nofault_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_fault == 2'b00);

    // R10: operand fields are zero when the result is not valid
    p_invalid_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_size64 && out_src == 4'd0));

    // R3: a register-form destination is never this instruction
    p_regform_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && modrm_mod == 2'b11) |=> out_fault == 2'b10);

    // R4: without the feature bit the result is never valid
    p_feat_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !feat_en) |=> (!out_valid && out_fault != 2'b00));

    // R5: a forbidden prefix never yields a valid result
    p_badpfx_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (pfx_lock || pfx_opsize)) |=> (!out_valid && out_fault != 2'b00));

    // R6: without REX.W the size stays 32 bits
    p_default32_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rex_w) |=> !out_size64);

    // R8: outside 64-bit mode neither the size nor the index extension rises
    p_legacy_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exec_mode != 2'b10) |=> (!out_size64 && !out_src[3]));

    // R7: the low index bits follow the reg field
    p_srclow_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_valid || out_src[2:0] == $past(modrm_reg)));
endmodule

bind dstore_decode_chk dstore_decode_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .pfx_lock  (pfx_lock),
    .pfx_opsize(pfx_opsize),
    .rex_w     (rex_w),
    .modrm_mod (modrm_mod),
    .modrm_reg (modrm_reg),
    .exec_mode (exec_mode),
    .feat_en   (feat_en),
    .out_valid (out_valid),
    .out_size64(out_size64),
    .out_src   (out_src),
    .out_fault (out_fault)
);

// File: tb/dstore_decode_chk_tb_top.sv
`timescale 1ns/1ps
module dstore_decode_chk_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        pfx_lock = 1'b0, pfx_opsize = 1'b0, pfx_rep = 1'b0, pfx_repne = 1'b0;
    logic        rex_present = 1'b0, rex_w = 1'b0, rex_r = 1'b0;
    logic [1:0]  op_len = 2'd0;
    logic [23:0] op_bytes = 24'd0;
    logic [1:0]  modrm_mod = 2'd0;
    logic [2:0]  modrm_reg = 3'd0;
    logic [1:0]  exec_mode = 2'd0;
    logic        feat_en = 1'b0;
    logic        out_valid, out_size64;
    logic [3:0]  out_src;
    logic [1:0]  out_fault;

    always #2.5 clk = ~clk;

    dstore_decode_chk dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .pfx_lock(pfx_lock), .pfx_opsize(pfx_opsize), .pfx_rep(pfx_rep), .pfx_repne(pfx_repne),
        .rex_present(rex_present), .rex_w(rex_w), .rex_r(rex_r),
        .op_len(op_len), .op_bytes(op_bytes), .modrm_mod(modrm_mod), .modrm_reg(modrm_reg),
        .exec_mode(exec_mode), .feat_en(feat_en),
        .out_valid(out_valid), .out_size64(out_size64), .out_src(out_src), .out_fault(out_fault)
    );

    typedef struct {
        logic       valid;
        logic       size64;
        logic [3:0] src;
        logic [1:0] fault;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    logic prev_in = 1'b0;
    bit   done = 1'b0;

    localparam logic [23:0] GOOD_OPC = 24'hF9380F;

    always @(posedge clk) prev_in <= rst ? 1'b0 : in_valid;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: compares each verdict cycle against the scoreboard; idle cycles must be quiet
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prev_in) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected verdict", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_valid == e.valid, e.tag, "valid", out_valid, e.valid);
                    check(out_fault == e.fault, e.tag, "fault", out_fault, e.fault);
                    check(out_size64 == e.size64, e.tag, "size64", out_size64, e.size64);
                    check(out_src == e.src, e.tag, "src", out_src, e.src);
                end
            end else begin
                check(!out_valid && out_fault == 2'b00, "R9", "idle outputs",
                      {out_valid, out_fault}, 0);
            end
        end
    end

    // Driver: sets fields at a falling edge, pulses in_valid, pushes the expected verdict
    task automatic drive(input string tag, input bit lk, input bit osz, input bit rp, input bit rn,
                         input bit rxp, input bit rxw, input bit rxr, input logic [1:0] len,
                         input logic [23:0] opc, input logic [1:0] md, input logic [2:0] rg,
                         input logic [1:0] mode, input bit fe, input bit keep);
        exp_t e;
        bit   recog, undef, long64;
        @(negedge clk);
        pfx_lock = lk; pfx_opsize = osz; pfx_rep = rp; pfx_repne = rn;
        rex_present = rxp; rex_w = rxw; rex_r = rxr;
        op_len = len; op_bytes = opc; modrm_mod = md; modrm_reg = rg;
        exec_mode = mode; feat_en = fe; in_valid = 1'b1;
        recog  = (len == 2'd3) && (opc == GOOD_OPC) && !rp && !rn && (md != 2'b11);
        undef  = lk || osz || !fe;
        long64 = (mode == 2'b10);
        e.tag = tag;
        if (!recog)     e.fault = 2'b10;
        else if (undef) e.fault = 2'b01;
        else            e.fault = 2'b00;
        e.valid  = (e.fault == 2'b00);
        e.size64 = e.valid && long64 && rxp && rxw;
        e.src    = e.valid ? {long64 && rxp && rxr, rg} : 4'd0;
        exp_q.push_back(e);
        if (!keep) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_size64 && out_src == 0 && out_fault == 0, "R1", "reset outputs",
              {out_valid, out_size64, out_src, out_fault}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && out_fault == 0, "R1", "after reset", {out_valid, out_fault}, 0);

        // R2: plain valid 32-bit store in protected mode
        drive("R2", 0,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b00, 3'd5, 2'b01, 1, 0);
        // R2: wrong last byte, wrong length, repeat prefixes
        drive("R2", 0,0,0,0, 0,0,0, 2'd3, 24'hF8380F, 2'b00, 3'd1, 2'b01, 1, 0);
        drive("R2", 0,0,0,0, 0,0,0, 2'd2, GOOD_OPC, 2'b00, 3'd1, 2'b01, 1, 0);
        drive("R2", 0,0,1,0, 0,0,0, 2'd3, GOOD_OPC, 2'b01, 3'd1, 2'b10, 1, 0);
        drive("R2", 0,0,0,1, 0,0,0, 2'd3, GOOD_OPC, 2'b10, 3'd1, 2'b10, 1, 0);
        // R2: mismatch beats undefined-opcode conditions
        drive("R2", 1,1,0,0, 0,0,0, 2'd3, 24'hF9390F, 2'b00, 3'd2, 2'b10, 0, 0);
        // R3: register form rejected, with and without lock; memory forms accepted
        drive("R3", 0,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b11, 3'd3, 2'b10, 1, 0);
        drive("R3", 1,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b11, 3'd3, 2'b01, 1, 0);
        drive("R3", 0,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b01, 3'd3, 2'b01, 1, 0);
        drive("R3", 0,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b10, 3'd3, 2'b00, 1, 0);
        // R4: feature disabled
        drive("R4", 0,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b00, 3'd4, 2'b01, 0, 0);
        drive("R4", 0,0,0,0, 1,1,1, 2'd3, GOOD_OPC, 2'b10, 3'd4, 2'b10, 0, 0);
        // R5: lock and operand-size override
        drive("R5", 1,0,0,0, 0,0,0, 2'd3, GOOD_OPC, 2'b00, 3'd6, 2'b01, 1, 0);
        drive("R5", 0,1,0,0, 1,1,0, 2'd3, GOOD_OPC, 2'b00, 3'd6, 2'b10, 1, 0);
        // R6: size selection in 64-bit mode
        drive("R6", 0,0,0,0, 1,1,0, 2'd3, GOOD_OPC, 2'b00, 3'd2, 2'b10, 1, 0);
        drive("R6", 0,0,0,0, 1,0,0, 2'd3, GOOD_OPC, 2'b00, 3'd2, 2'b10, 1, 0);
        drive("R6", 0,0,0,0, 0,1,0, 2'd3, GOOD_OPC, 2'b00, 3'd2, 2'b10, 1, 0);
        // R7: REX.R extension in 64-bit mode
        drive("R7", 0,0,0,0, 1,0,1, 2'd3, GOOD_OPC, 2'b01, 3'd7, 2'b10, 1, 0);
        drive("R7", 0,0,0,0, 1,1,1, 2'd3, GOOD_OPC, 2'b10, 3'd0, 2'b10, 1, 0);
        // R8: REX ignored outside 64-bit mode, in each other mode code
        for (int m = 0; m < 4; m++) begin
            if (m != 2)
                drive("R8", 0,0,0,0, 1,1,1, 2'd3, GOOD_OPC, 2'b00, 3'd6, 2'(m), 1, 0);
        end
        // R9/R10: back-to-back burst over every register and both fault kinds
        for (int r = 0; r < 8; r++) begin
            drive("R9", 0,0,0,0, 1,r[0],r[1], 2'd3, GOOD_OPC, 2'(r % 3), 3'(r), 2'b10, 1, 1);
        end
        drive("R10", 1,0,0,0, 1,1,1, 2'd3, GOOD_OPC, 2'b00, 3'd5, 2'b10, 1, 1);
        drive("R10", 0,0,0,0, 1,1,1, 2'd3, GOOD_OPC, 2'b11, 3'd5, 2'b10, 1, 1);
        drive("R10", 0,0,0,0, 1,1,1, 2'd3, GOOD_OPC, 2'b00, 3'd5, 2'b10, 1, 1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending verdicts", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule